// File: doc/BRIEF.md
# Port-Addressed PHY Management Command Engine

This block lets software reach a register inside an external PHY by naming a switch port. It does not need to know which management bus the PHY sits on or which PHY address it answers to. Configuration tables map every port to one of the management buses and to a 5-bit PHY address. A global word marks each bus as running Clause 22 or Clause 45 framing.

Software loads the target and the operands, then writes the command word with its start bit set. The engine resolves the port through the tables and checks that the command's clause matches the bus. If the checks pass, it hands exactly one request to the downstream MDIO master. When the response returns, it stores the read data and the fail status, and the busy bit drops. A command that fails its checks completes with the fail bit set and never reaches the bus.

The register interface is a single-cycle write strobe with a combinational read mux. The master side is a valid/ready request paired with a single-cycle response strobe.

Top module: `phy_cmd_engine`

## Requirements
- R1: After rst_ni is asserted, every readable register reads 0 and req_valid_o is 0.
- R2: The command word sits at index 1 and is laid out as follows.
  - Bit 0 is start/busy.
  - Bit 1 is the clause flag: 1 means Clause 45, 0 means Clause 22.
  - Bit 2 is the write flag: 1 means write, 0 means read.
  - Bits 14:3 hold the main page and bits 19:15 the park page.
  - Bits 24:20 hold the Clause 22 register number.
  - Bit 25 is the fail flag.
  - Bits 24:1 read back as they were last written.
- R3: Writing index 1 with bit 0 set while the engine is idle starts a command.
  - Bit 0 reads 1 from the next cycle until completion.
  - Each start issues at most one request.
  - Busy clears on the same clock edge that captures the response.
- R4: Read target: the port number sits in bits 31:16 of the data word at index 2. The request goes to that port's bus and PHY address. On completion the response data appears in bits 15:0 of index 2.
- R5: Write target: the port-select word at index 4 holds bit n for port n; when several bits are set, the lowest one wins. The request's write data is bits 31:16 of index 2. Bits 15:0 of index 2 are left unchanged.
- R6: For Clause 45, index 3 gives the device address in bits 20:16 and the register number in bits 15:0, and both are copied into the request. For Clause 22, the request's register field is the command's register number, zero-extended.
- R7: The PHY address table occupies indices 5 to 9. Port i sits in word 5+i/6 at bits (i%6)*5 +: 5. The bus table occupies indices 10 to 11. Port i sits in word 10+i/16 at bits (i%16)*2 +: 2. All table words read back as written.
- R8: Bits 19:16 of index 0 set Clause 45 mode for buses 0 to 3. A command whose clause flag disagrees with its bus's mode completes with fail set and issues no request.
- R9: A read naming a port of 28 or above, or a write whose select word has no port bit set, completes with fail set and issues no request.
- R10: On completion, the fail bit takes the response's fail flag. Starting a new command clears it.
- R11: While busy, writes to every register are ignored.
- R12: Once req_valid_o is raised, it stays high with every request field stable until req_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_o | output | 1 | Request to the MDIO master is valid |
| req_ready_i | input | 1 | MDIO master accepts the request |
| req_bus_o | output | 2 | Target management bus |
| req_phy_o | output | 5 | Target PHY address |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_c45_o | output | 1 | 1 for Clause 45 framing |
| req_devad_o | output | 5 | Clause 45 device address |
| req_reg_o | output | 16 | Register number |
| req_wdata_o | output | 16 | Write data |
| rsp_valid_i | input | 1 | Response strobe from the master |
| rsp_fail_i | input | 1 | Access failed |
| rsp_rdata_i | input | 16 | Read data |

## Verification
The bench aims at these corner cases:
- **Highest port.** Port 27 lives in the last word of each table, so a design with a wrong packing stride or word index sends it to the wrong PHY or bus.
- **Clause mismatch and invalid targets.** Commands on mismatched buses, read ports beyond the table, and empty select masks must fail without touching the bus. A design that lets them through raises the master's request count.
- **Writes while busy.** A second start and a select-word write arrive mid-command. If they were honoured, they would corrupt the command fields, issue a second request, or change the selection.
- **Stalled request and master failure.** The master holds off ready for two cycles and fails the access to PHY 31. A design that drops the request or changes its fields while stalled is caught. So is one that loses the fail flag, or fails to clear it on the next start.

// File: rtl/phy_cmd_pkg.sv
package phy_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT
  } eng_state_e;

  // command word bits 24:1
  typedef struct packed {
    logic [4:0]  reg_num;
    logic [4:0]  park_pg;
    logic [11:0] main_pg;
    logic        wr;
    logic        c45;
  } cmd_fields_t;

endpackage

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs #(
  parameter int NUM_PORTS = 28,
  parameter int NUM_BUSES = 4,
  parameter int PHY_AW    = 5,
  parameter int BUS_SEL_W = 2,
  parameter int REG_AW    = 4,
  parameter int GLB_IDX   = 0,
  parameter int ADDR_BASE = 5,
  parameter int BUS_BASE  = 10,
  localparam int PPW_A    = 32 / PHY_AW,
  localparam int PPW_B    = 32 / BUS_SEL_W,
  localparam int AWORDS   = (NUM_PORTS + PPW_A - 1) / PPW_A,
  localparam int BWORDS   = (NUM_PORTS + PPW_B - 1) / PPW_B
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [REG_AW-1:0]                    addr_i,
  input  logic [31:0]                          wdata_i,
  output logic [NUM_BUSES-1:0]                 bus_c45_o,
  output logic [NUM_PORTS-1:0][PHY_AW-1:0]     phy_tab_o,
  output logic [NUM_PORTS-1:0][BUS_SEL_W-1:0]  bus_tab_o,
  output logic                                 hit_o,
  output logic [31:0]                          rdata_o
);

  logic [AWORDS-1:0][31:0]  addr_words_q;
  logic [BWORDS-1:0][31:0]  bus_words_q;
  logic [NUM_BUSES-1:0]     c45_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c45_q <= '0;
    else if (wr_en_i && addr_i == REG_AW'(GLB_IDX)) c45_q <= wdata_i[16 +: NUM_BUSES];
  end

  for (genvar w = 0; w < AWORDS; w++) begin : g_aw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_words_q[w] <= '0;
      else if (wr_en_i && addr_i == REG_AW'(ADDR_BASE + w)) addr_words_q[w] <= wdata_i;
    end
  end

  for (genvar w = 0; w < BWORDS; w++) begin : g_bw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_words_q[w] <= '0;
      else if (wr_en_i && addr_i == REG_AW'(BUS_BASE + w)) bus_words_q[w] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign phy_tab_o[p] = addr_words_q[p / PPW_A][(p % PPW_A) * PHY_AW +: PHY_AW];
    assign bus_tab_o[p] = bus_words_q[p / PPW_B][(p % PPW_B) * BUS_SEL_W +: BUS_SEL_W];
  end

  assign bus_c45_o = c45_q;

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    if (addr_i == REG_AW'(GLB_IDX)) begin
      rdata_o[16 +: NUM_BUSES] = c45_q;
      hit_o = 1'b1;
    end
    for (int w = 0; w < AWORDS; w++) begin
      if (addr_i == REG_AW'(ADDR_BASE + w)) begin
        rdata_o = addr_words_q[w];
        hit_o   = 1'b1;
      end
    end
    for (int w = 0; w < BWORDS; w++) begin
      if (addr_i == REG_AW'(BUS_BASE + w)) begin
        rdata_o = bus_words_q[w];
        hit_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/phy_port_resolve.sv
module phy_port_resolve #(
  parameter int NUM_PORTS = 28,
  parameter int PHY_AW    = 5,
  parameter int BUS_SEL_W = 2,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                                 is_write_i,
  input  logic [15:0]                          port_num_i,
  input  logic [NUM_PORTS-1:0]                 port_mask_i,
  input  logic [NUM_PORTS-1:0][PHY_AW-1:0]     phy_tab_i,
  input  logic [NUM_PORTS-1:0][BUS_SEL_W-1:0]  bus_tab_i,
  output logic                                 ok_o,
  output logic [BUS_SEL_W-1:0]                 bus_o,
  output logic [PHY_AW-1:0]                    phy_o
);

  logic [PORT_W-1:0] sel;

  always_comb begin
    sel  = '0;
    ok_o = 1'b0;
    if (is_write_i) begin
      // descending scan: lowest set bit wins
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (port_mask_i[p]) begin
          sel  = PORT_W'(p);
          ok_o = 1'b1;
        end
      end
    end else begin
      ok_o = port_num_i < 16'(NUM_PORTS);
      sel  = port_num_i[PORT_W-1:0];
    end
  end

  always_comb begin
    bus_o = '0;
    phy_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel == PORT_W'(p)) begin
        bus_o = bus_tab_i[p];
        phy_o = phy_tab_i[p];
      end
    end
  end

endmodule

// File: rtl/phy_cmd_fsm.sv
module phy_cmd_fsm
  import phy_cmd_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int BUS_SEL_W = 2,
  parameter int PHY_AW    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  tgt_ok_i,
  input  logic [BUS_SEL_W-1:0]  tgt_bus_i,
  input  logic [PHY_AW-1:0]     tgt_phy_i,
  input  logic [NUM_BUSES-1:0]  bus_c45_i,
  input  logic                  cmd_wr_i,
  input  logic                  cmd_c45_i,
  input  logic [4:0]            cmd_reg_i,
  input  logic [4:0]            mmd_devad_i,
  input  logic [15:0]           mmd_reg_i,
  input  logic [15:0]           wdata_i,
  input  logic                  req_ready_i,
  input  logic                  rsp_valid_i,
  input  logic                  rsp_fail_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  done_fail_o,
  output logic                  rd_load_o,
  output logic                  req_valid_o,
  output logic [BUS_SEL_W-1:0]  req_bus_o,
  output logic [PHY_AW-1:0]     req_phy_o,
  output logic                  req_write_o,
  output logic                  req_c45_o,
  output logic [4:0]            req_devad_o,
  output logic [15:0]           req_reg_o,
  output logic [15:0]           req_wdata_o
);

  eng_state_e state_q, state_d;
  logic       mode_ok, load_req;

  assign mode_ok = (bus_c45_i[tgt_bus_i] == cmd_c45_i);

  always_comb begin
    state_d     = state_q;
    done_o      = 1'b0;
    done_fail_o = 1'b0;
    rd_load_o   = 1'b0;
    load_req    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (tgt_ok_i && mode_ok) begin
          load_req = 1'b1;
          state_d  = ST_ISSUE;
        end else begin
          done_o      = 1'b1;
          done_fail_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_ISSUE: if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid_i) begin
          done_o      = 1'b1;
          done_fail_o = rsp_fail_i;
          rd_load_o   = !req_write_o;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_bus_o   <= '0;
      req_phy_o   <= '0;
      req_write_o <= 1'b0;
      req_c45_o   <= 1'b0;
      req_devad_o <= '0;
      req_reg_o   <= '0;
      req_wdata_o <= '0;
    end else if (load_req) begin
      req_bus_o   <= tgt_bus_i;
      req_phy_o   <= tgt_phy_i;
      req_write_o <= cmd_wr_i;
      req_c45_o   <= cmd_c45_i;
      req_devad_o <= cmd_c45_i ? mmd_devad_i : 5'd0;
      req_reg_o   <= cmd_c45_i ? mmd_reg_i : {11'd0, cmd_reg_i};
      req_wdata_o <= wdata_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_ISSUE);

endmodule

// File: rtl/phy_cmd_engine.sv
module phy_cmd_engine
  import phy_cmd_pkg::*;
#(
  parameter int NUM_PORTS  = 28,
  parameter int NUM_BUSES  = 4,
  parameter int PHY_AW     = 5,
  localparam int BUS_SEL_W = $clog2(NUM_BUSES),
  localparam int PPW_A     = 32 / PHY_AW,
  localparam int PPW_B     = 32 / BUS_SEL_W,
  localparam int AWORDS    = (NUM_PORTS + PPW_A - 1) / PPW_A,
  localparam int BWORDS    = (NUM_PORTS + PPW_B - 1) / PPW_B,
  localparam int GLB_IDX   = 0,
  localparam int CMD_IDX   = 1,
  localparam int DATA_IDX  = 2,
  localparam int MMD_IDX   = 3,
  localparam int PSEL_IDX  = 4,
  localparam int ADDR_BASE = 5,
  localparam int BUS_BASE  = ADDR_BASE + AWORDS,
  localparam int REG_AW    = $clog2(BUS_BASE + BWORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [BUS_SEL_W-1:0]  req_bus_o,
  output logic [PHY_AW-1:0]     req_phy_o,
  output logic                  req_write_o,
  output logic                  req_c45_o,
  output logic [4:0]            req_devad_o,
  output logic [15:0]           req_reg_o,
  output logic [15:0]           req_wdata_o,
  input  logic                  rsp_valid_i,
  input  logic                  rsp_fail_i,
  input  logic [15:0]           rsp_rdata_i
);

  cmd_fields_t                        cmd_q;
  logic                               fail_q;
  logic [15:0]                        data_in_q, data_out_q;
  logic [4:0]                         mmd_devad_q;
  logic [15:0]                        mmd_reg_q;
  logic [NUM_PORTS-1:0]               psel_q;
  logic                               busy, done, done_fail, rd_load;
  logic                               wr_ok, start;
  logic [NUM_BUSES-1:0]               bus_c45;
  logic [NUM_PORTS-1:0][PHY_AW-1:0]   phy_tab;
  logic [NUM_PORTS-1:0][BUS_SEL_W-1:0] bus_tab;
  logic                               cfg_hit;
  logic [31:0]                        cfg_rdata;
  logic                               tgt_ok;
  logic [BUS_SEL_W-1:0]               tgt_bus;
  logic [PHY_AW-1:0]                  tgt_phy;

  assign wr_ok = reg_we_i && !busy;
  assign start = wr_ok && reg_addr_i == REG_AW'(CMD_IDX) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      fail_q      <= 1'b0;
      data_in_q   <= '0;
      data_out_q  <= '0;
      mmd_devad_q <= '0;
      mmd_reg_q   <= '0;
      psel_q      <= '0;
    end else begin
      if (wr_ok && reg_addr_i == REG_AW'(CMD_IDX)) cmd_q <= reg_wdata_i[24:1];
      if (start)     fail_q <= 1'b0;
      else if (done) fail_q <= done_fail;
      if (wr_ok && reg_addr_i == REG_AW'(DATA_IDX)) data_in_q <= reg_wdata_i[31:16];
      if (rd_load) data_out_q <= rsp_rdata_i;
      if (wr_ok && reg_addr_i == REG_AW'(MMD_IDX)) begin
        mmd_devad_q <= reg_wdata_i[20:16];
        mmd_reg_q   <= reg_wdata_i[15:0];
      end
      if (wr_ok && reg_addr_i == REG_AW'(PSEL_IDX)) psel_q <= reg_wdata_i[NUM_PORTS-1:0];
    end
  end

  phy_cfg_regs #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_BUSES (NUM_BUSES),
    .PHY_AW    (PHY_AW),
    .BUS_SEL_W (BUS_SEL_W),
    .REG_AW    (REG_AW),
    .GLB_IDX   (GLB_IDX),
    .ADDR_BASE (ADDR_BASE),
    .BUS_BASE  (BUS_BASE)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .bus_c45_o (bus_c45),
    .phy_tab_o (phy_tab),
    .bus_tab_o (bus_tab),
    .hit_o     (cfg_hit),
    .rdata_o   (cfg_rdata)
  );

  phy_port_resolve #(
    .NUM_PORTS (NUM_PORTS),
    .PHY_AW    (PHY_AW),
    .BUS_SEL_W (BUS_SEL_W)
  ) u_resolve (
    .is_write_i  (cmd_q.wr),
    .port_num_i  (data_in_q),
    .port_mask_i (psel_q),
    .phy_tab_i   (phy_tab),
    .bus_tab_i   (bus_tab),
    .ok_o        (tgt_ok),
    .bus_o       (tgt_bus),
    .phy_o       (tgt_phy)
  );

  phy_cmd_fsm #(
    .NUM_BUSES (NUM_BUSES),
    .BUS_SEL_W (BUS_SEL_W),
    .PHY_AW    (PHY_AW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .tgt_ok_i    (tgt_ok),
    .tgt_bus_i   (tgt_bus),
    .tgt_phy_i   (tgt_phy),
    .bus_c45_i   (bus_c45),
    .cmd_wr_i    (cmd_q.wr),
    .cmd_c45_i   (cmd_q.c45),
    .cmd_reg_i   (cmd_q.reg_num),
    .mmd_devad_i (mmd_devad_q),
    .mmd_reg_i   (mmd_reg_q),
    .wdata_i     (data_in_q),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_fail_i  (rsp_fail_i),
    .busy_o      (busy),
    .done_o      (done),
    .done_fail_o (done_fail),
    .rd_load_o   (rd_load),
    .req_valid_o (req_valid_o),
    .req_bus_o   (req_bus_o),
    .req_phy_o   (req_phy_o),
    .req_write_o (req_write_o),
    .req_c45_o   (req_c45_o),
    .req_devad_o (req_devad_o),
    .req_reg_o   (req_reg_o),
    .req_wdata_o (req_wdata_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_AW'(CMD_IDX))       reg_rdata_o = {6'd0, fail_q, cmd_q, busy};
    else if (reg_addr_i == REG_AW'(DATA_IDX)) reg_rdata_o = {data_in_q, data_out_q};
    else if (reg_addr_i == REG_AW'(MMD_IDX))  reg_rdata_o = {11'd0, mmd_devad_q, mmd_reg_q};
    else if (reg_addr_i == REG_AW'(PSEL_IDX)) reg_rdata_o[NUM_PORTS-1:0] = psel_q;
    else if (cfg_hit)                         reg_rdata_o = cfg_rdata;
  end

endmodule

// File: rtl/phy_cmd_engine_chk.sv
module phy_cmd_engine_chk #(
  parameter int NUM_PORTS = 28,
  parameter int NUM_BUSES = 4,
  parameter int BUS_SEL_W = 2,
  parameter int PHY_AW    = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  busy_i,
  input logic                  reg_we_i,
  input logic [23:0]           cmd_i,
  input logic [15:0]           data_in_i,
  input logic [20:0]           mmd_i,
  input logic [NUM_PORTS-1:0]  psel_i,
  input logic [NUM_BUSES-1:0]  bus_c45_i,
  input logic                  req_valid_i,
  input logic                  req_ready_i,
  input logic [BUS_SEL_W-1:0]  req_bus_i,
  input logic [PHY_AW-1:0]     req_phy_i,
  input logic                  req_write_i,
  input logic                  req_c45_i,
  input logic [4:0]            req_devad_i,
  input logic [15:0]           req_reg_i,
  input logic [15:0]           req_wdata_i,
  input logic                  rsp_valid_i
);

  logic outstanding_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         outstanding_q <= 1'b0;
    else if (req_valid_i && req_ready_i) outstanding_q <= 1'b1;
    else if (rsp_valid_i)                outstanding_q <= 1'b0;
  end

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_i |=> req_valid_i &&
      $stable({req_bus_i, req_phy_i, req_write_i, req_c45_i, req_devad_i, req_reg_i, req_wdata_i}));

  assert_rsp_clears_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q && rsp_valid_i |=> !busy_i);

  assert_single_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> busy_i && !outstanding_q);

  assert_mode_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> req_c45_i == bus_c45_i[req_bus_i]);

  assert_busy_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && reg_we_i |=> $stable({cmd_i, data_in_i, mmd_i, psel_i, bus_c45_i}));

endmodule

bind phy_cmd_engine phy_cmd_engine_chk #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_BUSES (NUM_BUSES),
  .BUS_SEL_W (BUS_SEL_W),
  .PHY_AW    (PHY_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .reg_we_i    (reg_we_i),
  .cmd_i       (cmd_q),
  .data_in_i   (data_in_q),
  .mmd_i       ({mmd_devad_q, mmd_reg_q}),
  .psel_i      (psel_q),
  .bus_c45_i   (bus_c45),
  .req_valid_i (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_bus_i   (req_bus_o),
  .req_phy_i   (req_phy_o),
  .req_write_i (req_write_o),
  .req_c45_i   (req_c45_o),
  .req_devad_i (req_devad_o),
  .req_reg_i   (req_reg_o),
  .req_wdata_i (req_wdata_o),
  .rsp_valid_i (rsp_valid_i)
);

// File: tb/tb_phy_cmd_engine.sv
`timescale 1ns/1ps
module tb_phy_cmd_engine;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [1:0]  req_bus;
  logic [4:0]  req_phy, req_devad;
  logic        req_write, req_c45;
  logic [15:0] req_reg, req_wdata;
  logic        rsp_valid = 1'b0, rsp_fail = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int n_chk = 0, n_err = 0, n_req = 0;
  bit finished = 0;
  logic [1:0]  cap_bus;
  logic [4:0]  cap_phy, cap_devad;
  logic        cap_wr, cap_c45;
  logic [15:0] cap_reg, cap_wdata;

  always #10 clk = ~clk;

  phy_cmd_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_bus_o(req_bus), .req_phy_o(req_phy),
    .req_write_o(req_write), .req_c45_o(req_c45), .req_devad_o(req_devad),
    .req_reg_o(req_reg), .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid),
    .rsp_fail_i(rsp_fail), .rsp_rdata_i(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] phy_of(input int p);
    return (p == 9) ? 5'd31 : 5'((p * 3 + 1) % 31);
  endfunction

  function automatic logic [1:0] bus_of(input int p);
    return 2'(p % 4);
  endfunction

  // MDIO master stub: stalls ready two cycles, answers two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        cap_bus = req_bus; cap_phy = req_phy; cap_wr = req_write; cap_c45 = req_c45;
        cap_devad = req_devad; cap_reg = req_reg; cap_wdata = req_wdata;
        repeat (2) @(negedge clk);
        chk("R12 valid held", {31'd0, req_valid}, 32'd1);
        chk("R12 fields stable", {req_bus, req_phy, req_write, req_c45, req_devad, req_reg[8:0]},
            {cap_bus, cap_phy, cap_wr, cap_c45, cap_devad, cap_reg[8:0]});
        n_req++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_fail  = (cap_phy == 5'd31);
        rsp_rdata = {cap_bus, cap_phy, cap_reg[8:0]};
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_fail  = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 100; i++) begin
      reg_read(4'd1, d);
      if (!d[0]) return;
      @(negedge clk);
    end
    chk("R3 completion timeout", 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] rn, input logic wr, input logic c45);
    return {7'd0, rn, 5'h1f, 12'hfff, wr, c45, 1'b1};
  endfunction

  // {port, wr, c45, reg, devad, wdata}
  localparam logic [43:0] VEC [8] = '{
    {5'd0,  1'b0, 1'b0, 16'h0002, 5'd0,  16'h0000},
    {5'd1,  1'b1, 1'b0, 16'h0004, 5'd0,  16'hA5A5},
    {5'd2,  1'b0, 1'b1, 16'h1234, 5'd1,  16'h0000},
    {5'd7,  1'b1, 1'b1, 16'hBEEF, 5'd30, 16'h1357},
    {5'd27, 1'b0, 1'b1, 16'hFFFF, 5'd7,  16'h0000},
    {5'd4,  1'b0, 1'b1, 16'h0011, 5'd3,  16'h0000},
    {5'd6,  1'b1, 1'b0, 16'h0005, 5'd0,  16'h2222},
    {5'd9,  1'b1, 1'b0, 16'h0001, 5'd0,  16'h3333}
  };

  initial begin
    logic [31:0] d, exp_lo;
    logic [31:0] aw [5];
    logic [31:0] bw [2];
    int n0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      reg_read(4'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 32'd0);
    end
    chk("R1 req_valid after reset", {31'd0, req_valid}, 32'd0);

    // configuration, packing per R7
    for (int w = 0; w < 5; w++) aw[w] = '0;
    for (int w = 0; w < 2; w++) bw[w] = '0;
    for (int p = 0; p < 28; p++) begin
      aw[p / 6][(p % 6) * 5 +: 5] = phy_of(p);
      bw[p / 16][(p % 16) * 2 +: 2] = bus_of(p);
    end
    for (int w = 0; w < 5; w++) reg_write(4'(5 + w), aw[w]);
    for (int w = 0; w < 2; w++) reg_write(4'(10 + w), bw[w]);
    reg_write(4'd0, 32'h000C_0000);  // buses 2,3 in Clause 45 (R8)
    @(negedge clk);
    reg_read(4'd6, d);  chk("R7 addr word readback", d, aw[1]);
    reg_read(4'd11, d); chk("R7 bus word readback", d, bw[1]);
    reg_read(4'd0, d);  chk("R8 global readback", d, 32'h000C_0000);

    exp_lo = 32'd0;
    for (int i = 0; i < 8; i++) begin
      logic [4:0] p; logic wr, c45, mism, fexp; logic [15:0] rg, wd; logic [4:0] dv;
      logic [15:0] exp_reg;
      {p, wr, c45, rg, dv, wd} = VEC[i];
      mism = (c45 != (bus_of(int'(p)) >= 2'd2));
      fexp = mism || (wr && phy_of(int'(p)) == 5'd31);
      exp_reg = c45 ? rg : {11'd0, rg[4:0]};
      if (wr) begin
        reg_write(4'd4, 32'd1 << p);
        reg_write(4'd2, {wd, 16'h0000});
      end else begin
        reg_write(4'd2, {11'd0, p, 16'h0000});
      end
      reg_write(4'd3, {11'd0, dv, rg});
      n0 = n_req;
      reg_write(4'd1, cmd_word(rg[4:0], wr, c45));
      reg_read(4'd1, d);
      chk($sformatf("R3 busy after start v%0d", i), {31'd0, d[0]}, 32'd1);
      wait_idle();
      reg_read(4'd1, d);
      chk($sformatf("R10 fail flag v%0d", i), {31'd0, d[25]}, {31'd0, fexp});
      chk($sformatf("R2 fields readback v%0d", i), {8'd0, d[24:1]}, {8'd0, cmd_word(rg[4:0], wr, c45)} >> 1 & 32'h00FF_FFFF);
      chk($sformatf("R8 R3 request count v%0d", i), 32'(n_req - n0), mism ? 32'd0 : 32'd1);
      if (!mism) begin
        chk($sformatf("R4 R7 bus/phy v%0d", i), {25'd0, cap_bus, cap_phy},
            {25'd0, bus_of(int'(p)), phy_of(int'(p))});
        chk($sformatf("R6 clause/reg/devad v%0d", i), {cap_wr, cap_c45, cap_devad, 9'd0, cap_reg},
            {wr, c45, c45 ? dv : 5'd0, 9'd0, exp_reg});
        if (wr) chk($sformatf("R5 write data v%0d", i), {16'd0, cap_wdata}, {16'd0, wd});
        if (!wr) exp_lo = {16'd0, bus_of(int'(p)), phy_of(int'(p)), exp_reg[8:0]};
      end
      reg_read(4'd2, d);
      chk($sformatf("R4 R5 data low v%0d", i), {16'd0, d[15:0]}, exp_lo);
    end

    // R10: a new start clears the previous fail (last vector failed)
    reg_write(4'd2, 32'h0000_0000);
    reg_write(4'd1, cmd_word(5'd3, 1'b0, 1'b0));
    reg_read(4'd1, d);
    chk("R10 fail cleared by start", {30'd0, d[25], d[0]}, 32'd1);
    // R11: writes during busy ignored
    n0 = n_req;
    reg_write(4'd1, cmd_word(5'd17, 1'b1, 1'b1));
    reg_write(4'd4, 32'h0000_000F);
    wait_idle();
    reg_read(4'd1, d);
    chk("R11 cmd unchanged", {27'd0, d[24:20]}, 32'd3);
    chk("R11 R3 one request", 32'(n_req - n0), 32'd1);
    reg_read(4'd4, d);
    chk("R11 select unchanged", d, 32'd1 << 9);

    // R9: read port out of range
    reg_write(4'd2, {16'd28, 16'd0});
    n0 = n_req;
    reg_write(4'd1, cmd_word(5'd1, 1'b0, 1'b0));
    wait_idle();
    reg_read(4'd1, d);
    chk("R9 port 28 fails", {31'd0, d[25]}, 32'd1);
    chk("R9 port 28 no request", 32'(n_req - n0), 32'd0);

    // R9: empty write mask
    reg_write(4'd4, 32'd0);
    reg_write(4'd1, cmd_word(5'd1, 1'b1, 1'b0));
    wait_idle();
    reg_read(4'd1, d);
    chk("R9 empty mask fails", {31'd0, d[25]}, 32'd1);
    chk("R9 empty mask no request", 32'(n_req - n0), 32'd0);

    // R5: several mask bits, lowest wins (port 3, bus 3, Clause 45)
    reg_write(4'd4, (32'd1 << 10) | (32'd1 << 3));
    reg_write(4'd2, 32'h4242_0000);
    reg_write(4'd1, cmd_word(5'd0, 1'b1, 1'b1));
    wait_idle();
    chk("R5 lowest select bit", {25'd0, cap_bus, cap_phy}, {25'd0, bus_of(3), phy_of(3)});
    reg_read(4'd1, d);
    chk("R5 multi-select ok", {31'd0, d[25]}, 32'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule